// File: doc/BRIEF.md
# Non-blocking Data Miss Tracker

This block sits beside the issue stage of a pipeline whose data cache keeps running while misses are pending. When the cache reports a miss, the tracker records the miss's line address and the set of registers that wait for the returning line in a small pool of entries (two by default). A further miss to a line that is already tracked joins the existing entry, so one fill can satisfy several requests.

Every cycle the tracker rules on the instruction offered for issue. It holds back an instruction that reads a register still waiting on a pending line, and it holds back any memory instruction when no entry would be left for it. Other instructions keep flowing. When memory returns a line, the matching entry is freed in that same cycle and the waiting registers are announced by a single-cycle wakeup. The cache arrays, the fill datapath and memory arbitration lie outside the block. A miss is reported in the cycle after its memory instruction issued.

Top module: `pend_miss_trk`

## Requirements
- R1: After reset no entry is busy: `iss_stall` is 0 for any offered instruction and `wake_valid` is 0.
- R2: A pending miss by itself stalls nothing: an instruction whose enabled sources are not waiting registers issues (`iss_stall`=0), and a memory instruction also issues while at least one entry stays free.
- R3: An offered instruction (`iss_valid`=1) whose enabled source (source i is `iss_src[i*5 +: 5]`, enabled by `iss_src_en[i]`) names a register waiting on a tracked line, or the destination of a load miss reported in the same cycle, gets `iss_stall`=1; a disabled source never causes a stall, and `iss_stall` is 0 whenever `iss_valid` is 0.
- R4: A store miss (`miss_store`=1) occupies an entry but adds no waiting register, so its `miss_rd` value causes no stall.
- R5: When all entries (two) are busy after this cycle's release and allocation, an offered memory instruction (`iss_mem`=1) stalls, while a non-memory instruction without a dependency does not.
- R6: A miss whose line address equals that of a busy entry not released this cycle merges into it: no second entry is taken, and its register is added to that entry's waiting set.
- R7: A fill (`fill_valid`, `fill_line`) matching a busy entry frees it in that cycle; `wake_valid` is 1 in that cycle only, with `wake_mask` bit r set for every register r waiting on the entry, and dependency stalls on those registers end in that cycle. A fill matching no entry gives no wakeup.
- R8: Release and allocation in the same cycle both take effect: the structural stall uses the entry count after the release plus any new allocation, and a freed entry may be refilled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_mem | input | 1 | The offered instruction is a load or store |
| iss_src | input | NSRC*REG_W | Source register numbers, source i at bits i*REG_W |
| iss_src_en | input | NSRC | Source i is read by the offered instruction |
| iss_stall | output | 1 | Hold the offered instruction this cycle |
| miss_valid | input | 1 | The cache reports a miss this cycle |
| miss_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the miss |
| miss_store | input | 1 | The miss belongs to a store |
| miss_rd | input | REG_W | Destination register of a load miss |
| fill_valid | input | 1 | A line returns from memory this cycle |
| fill_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the returning data |
| wake_valid | output | 1 | Single-cycle wakeup for released registers |
| wake_mask | output | 2**REG_W | One bit per register released this cycle |

## Verification
The stall and wakeup outputs are combinational: each is due in the same cycle as the issue, miss or fill that causes it, while the effect on the entries appears from the next rising edge. The bench drives inputs at the falling edge, samples both outputs one nanosecond later, and only then advances its reference entry model at the rising edge, so every comparison sees a complete, settled cycle. Directed cycles place release and allocation in the same cycle, merge into a store entry, and fill unknown lines; random cycles report each miss one cycle after a memory instruction was let through.

// File: rtl/mtk_pkg.sv
package mtk_pkg;

   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mtk_entry.sv
module mtk_entry #(
   parameter int unsigned LINE_W = 27,
   parameter int unsigned NREGS  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              merge_i,
   input  logic              release_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [NREGS-1:0]  add_i,
   output logic              valid_o,
   output logic [LINE_W-1:0] line_o,
   output logic [NREGS-1:0]  wait_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         line_o  <= '0;
         wait_o  <= '0;
      end else if (alloc_i) begin
         valid_o <= 1'b1;
         line_o  <= line_i;
         wait_o  <= add_i;
      end else if (release_i) begin
         valid_o <= 1'b0;
         wait_o  <= '0;
      end else if (merge_i) begin
         wait_o  <= wait_o | add_i;
      end
   end

   // R7: a released entry that is not refilled is free on the next cycle
   a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !alloc_i) |=> !valid_o);

   // R6: a merge keeps the entry busy on the same line
   a_r6_merge_keeps_line: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && merge_i && !release_i && !alloc_i) |=> (valid_o && $stable(line_o)));

endmodule

// File: rtl/mtk_pick.sv
module mtk_pick #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] free_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);

   assign any_o = |free_i;

   generate
      if (N == 1) begin : g_single
         assign grant_o = free_i;
      end else begin : g_prio
         always_comb begin
            logic taken;
            taken   = 1'b0;
            grant_o = '0;
            for (int i = 0; i < N; i++) begin
               if (free_i[i] && !taken) begin
                  grant_o[i] = 1'b1;
                  taken      = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mtk_hazard.sv
module mtk_hazard #(
   parameter int unsigned NSRC  = 2,
   parameter int unsigned REG_W = 5,
   parameter int unsigned NREGS = 32
) (
   input  logic [NSRC*REG_W-1:0] src_i,
   input  logic [NSRC-1:0]       src_en_i,
   input  logic [NREGS-1:0]      pend_i,
   output logic                  dep_o
);

   logic [NSRC-1:0] hit;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign hit[i] = src_en_i[i] & pend_i[src_i[i*REG_W +: REG_W]];
      end
   endgenerate

   assign dep_o = |hit;

endmodule

// File: rtl/pend_miss_trk.sv
module pend_miss_trk #(
   parameter int unsigned ENTRIES    = 2,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned REG_W      = 5,
   parameter int unsigned NSRC       = 2,
   localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
   localparam int unsigned LINE_W    = ADDR_W - OFF_W,
   localparam int unsigned NREGS     = 1 << REG_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  iss_valid,
   input  logic                  iss_mem,
   input  logic [NSRC*REG_W-1:0] iss_src,
   input  logic [NSRC-1:0]       iss_src_en,
   output logic                  iss_stall,
   input  logic                  miss_valid,
   input  logic [LINE_W-1:0]     miss_line,
   input  logic                  miss_store,
   input  logic [REG_W-1:0]      miss_rd,
   input  logic                  fill_valid,
   input  logic [LINE_W-1:0]     fill_line,
   output logic                  wake_valid,
   output logic [NREGS-1:0]      wake_mask
);
   import mtk_pkg::*;

   localparam int unsigned CNT_W = idx_width(ENTRIES + 2) + 1;

   generate
      if (ENTRIES < 1 || ENTRIES > 8) begin : g_bad_entries
         $error("pend_miss_trk: ENTRIES must lie in 1..8");
      end
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("pend_miss_trk: LINE_BYTES must be a power of two");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("pend_miss_trk: ADDR_W must exceed the line offset width");
      end
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
         $error("pend_miss_trk: REG_W must lie in 1..8");
      end
      if (NSRC < 1) begin : g_bad_src
         $error("pend_miss_trk: NSRC must be at least 1");
      end
   endgenerate

   logic              ent_valid [ENTRIES];
   logic [LINE_W-1:0] ent_line  [ENTRIES];
   logic [NREGS-1:0]  ent_wait  [ENTRIES];

   logic [ENTRIES-1:0] rel, live, mhit, free, grant, alloc;
   logic               merge_any, new_alloc, any_free, dep;
   logic [NREGS-1:0]   miss_mask, pend_mask;
   logic [CNT_W-1:0]   occ_after;
   acc_kind_e          miss_kind;

   assign miss_kind = acc_kind_e'(miss_store);
   assign miss_mask = (miss_valid && miss_kind == ACC_LOAD) ? (NREGS'(1) << miss_rd) : '0;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         assign rel[e]   = fill_valid & ent_valid[e] & (ent_line[e] == fill_line);
         assign live[e]  = ent_valid[e] & ~rel[e];
         assign mhit[e]  = miss_valid & live[e] & (ent_line[e] == miss_line);
         assign free[e]  = ~live[e];
         assign alloc[e] = new_alloc & grant[e];

         mtk_entry #(
            .LINE_W (LINE_W),
            .NREGS  (NREGS)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc[e]),
            .merge_i   (mhit[e]),
            .release_i (rel[e]),
            .line_i    (miss_line),
            .add_i     (miss_mask),
            .valid_o   (ent_valid[e]),
            .line_o    (ent_line[e]),
            .wait_o    (ent_wait[e])
         );
      end
   endgenerate

   assign merge_any = |mhit;
   assign new_alloc = miss_valid & ~merge_any;

   mtk_pick #(.N(ENTRIES)) u_pick (
      .free_i  (free),
      .grant_o (grant),
      .any_o   (any_free)
   );

   always_comb begin
      wake_mask = '0;
      pend_mask = miss_mask;
      occ_after = CNT_W'(new_alloc);
      for (int e = 0; e < ENTRIES; e++) begin
         if (rel[e])  wake_mask = wake_mask | ent_wait[e];
         if (live[e]) pend_mask = pend_mask | ent_wait[e];
         occ_after = occ_after + CNT_W'(live[e]);
      end
   end

   assign wake_valid = |wake_mask;

   mtk_hazard #(
      .NSRC  (NSRC),
      .REG_W (REG_W),
      .NREGS (NREGS)
   ) u_hazard (
      .src_i    (iss_src),
      .src_en_i (iss_src_en),
      .pend_i   (pend_mask),
      .dep_o    (dep)
   );

   assign iss_stall = iss_valid & (dep | (iss_mem & (occ_after >= CNT_W'(ENTRIES))));

   // R5: a new miss always finds a free entry or an entry to join
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (merge_any || any_free));

   // R7: a wakeup is only ever caused by a returning line
   a_r7_wake_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> fill_valid);

   // R2: a non-memory instruction without a dependency is never held
   a_r2_nonmem_free: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_mem && !dep) |-> !iss_stall);

   // R8: at most one entry is granted, and only a free one
   a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r8_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(grant & ~free)));

endmodule

// File: tb/pend_miss_trk_tb.sv
`timescale 1ns/1ps
module pend_miss_trk_tb;

   localparam int ENTRIES = 2;
   localparam int LINE_W  = 27;
   localparam int REG_W   = 5;
   localparam int NREGS   = 32;
   localparam int NSRC    = 2;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  iss_valid, iss_mem;
   logic [NSRC*REG_W-1:0] iss_src;
   logic [NSRC-1:0]       iss_src_en;
   logic                  iss_stall;
   logic                  miss_valid, miss_store;
   logic [LINE_W-1:0]     miss_line, fill_line;
   logic [REG_W-1:0]      miss_rd;
   logic                  fill_valid;
   logic                  wake_valid;
   logic [NREGS-1:0]      wake_mask;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   pend_miss_trk u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_mem(iss_mem), .iss_src(iss_src),
      .iss_src_en(iss_src_en), .iss_stall(iss_stall),
      .miss_valid(miss_valid), .miss_line(miss_line), .miss_store(miss_store),
      .miss_rd(miss_rd), .fill_valid(fill_valid), .fill_line(fill_line),
      .wake_valid(wake_valid), .wake_mask(wake_mask)
   );

   // reference entries
   bit               m_valid [ENTRIES];
   logic [LINE_W-1:0] m_line [ENTRIES];
   logic [NREGS-1:0]  m_wait [ENTRIES];
   bit               last_stall;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_eval(output bit e_stall, output bit e_dep, output bit e_full,
                             output logic [NREGS-1:0] e_wake);
      bit rel, mrg;
      int cnt;
      logic [NREGS-1:0] pend;
      pend   = (miss_valid && !miss_store) ? (NREGS'(1) << miss_rd) : '0;
      e_wake = '0;
      mrg    = 0;
      cnt    = 0;
      for (int e = 0; e < ENTRIES; e++) begin
         rel = fill_valid && m_valid[e] && m_line[e] == fill_line;
         if (rel) e_wake |= m_wait[e];
         if (m_valid[e] && !rel) begin
            cnt++;
            pend |= m_wait[e];
            if (miss_valid && m_line[e] == miss_line) mrg = 1;
         end
      end
      if (miss_valid && !mrg) cnt++;
      e_dep = 0;
      for (int s = 0; s < NSRC; s++)
         if (iss_src_en[s] && pend[iss_src[s*REG_W +: REG_W]]) e_dep = 1;
      e_full  = cnt >= ENTRIES;
      e_stall = iss_valid && (e_dep || (iss_mem && e_full));
   endtask

   task automatic model_commit();
      bit rel [ENTRIES];
      bit mrg;
      logic [NREGS-1:0] add;
      add = (miss_valid && !miss_store) ? (NREGS'(1) << miss_rd) : '0;
      mrg = 0;
      for (int e = 0; e < ENTRIES; e++) begin
         rel[e] = fill_valid && m_valid[e] && m_line[e] == fill_line;
         if (rel[e]) begin m_valid[e] = 0; m_wait[e] = '0; end
      end
      for (int e = 0; e < ENTRIES; e++)
         if (miss_valid && m_valid[e] && m_line[e] == miss_line) begin
            m_wait[e] |= add; mrg = 1;
         end
      if (miss_valid && !mrg) begin
         bit placed;
         placed = 0;
         for (int e = 0; e < ENTRIES; e++)
            if (!m_valid[e] && !placed) begin
               m_valid[e] = 1; m_line[e] = miss_line; m_wait[e] = add; placed = 1;
            end
      end
   endtask

   task automatic idle();
      iss_valid = 0; iss_mem = 0; iss_src = '0; iss_src_en = '0;
      miss_valid = 0; miss_line = '0; miss_store = 0; miss_rd = '0;
      fill_valid = 0; fill_line = '0;
   endtask

   // exp_s < 0: stall expectation from the model only
   task automatic cyc(input string tag, input int exp_s);
      bit es, ed, ef;
      logic [NREGS-1:0] ew;
      #1;
      model_eval(es, ed, ef, ew);
      if (exp_s >= 0) chk({tag, " stall(directed)"}, 64'(iss_stall), 64'(exp_s));
      chk({tag, " stall"}, 64'(iss_stall), 64'(es));
      chk("R7 wake_valid", 64'(wake_valid), 64'(ew != '0));
      chk("R7 wake_mask", 64'(wake_mask), 64'(ew));
      last_stall = es;
      @(posedge clk);
      model_commit();
      @(negedge clk);
   endtask

   task automatic issue(input bit mem, input int a, input bit a_en, input int b, input bit b_en);
      iss_valid = 1; iss_mem = mem;
      iss_src = {REG_W'(b), REG_W'(a)}; iss_src_en = {b_en, a_en};
   endtask

   initial begin
      #(100000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int e = 0; e < ENTRIES; e++) begin m_valid[e] = 0; m_line[e] = '0; m_wait[e] = '0; end
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      issue(1, 3, 1, 4, 1);
      #1;
      chk("R1 stall in reset", 64'(iss_stall), 64'd0);
      chk("R1 wake in reset", 64'(wake_valid), 64'd0);
      @(posedge clk); @(negedge clk);
      rst_n = 1;
      idle(); issue(1, 3, 1, 4, 1);
      cyc("R1", 0);

      // A: load miss line 0x10 -> r3, independent memory issue
      idle(); miss_valid = 1; miss_line = 27'h10; miss_rd = 5'd3; issue(1, 4, 1, 5, 1);
      cyc("R2", 0);
      idle(); issue(0, 3, 1, 0, 0);            cyc("R3", 1);
      idle(); issue(0, 3, 0, 6, 1);            cyc("R3 disabled source", 0);
      idle(); iss_src = 10'(3); iss_src_en = 2'b01; cyc("R3 no offer", 0);
      // store miss line 0x20, rd 7 ignored
      idle(); miss_valid = 1; miss_line = 27'h20; miss_store = 1; miss_rd = 5'd7;
      issue(0, 7, 1, 0, 0);                    cyc("R4", 0);
      idle(); issue(1, 8, 1, 9, 1);            cyc("R5", 1);
      idle(); issue(0, 8, 1, 0, 0);            cyc("R5", 0);
      // fill 0x10: release with memory issue in the same cycle
      idle(); fill_valid = 1; fill_line = 27'h10; issue(1, 9, 1, 0, 0);
      #1;
      chk("R7 wake pulse", 64'(wake_mask), 64'(32'h8));
      cyc("R8", 0);
      idle(); issue(0, 3, 1, 0, 0);            cyc("R7 released", 0);
      // merge a load into the store entry
      idle(); miss_valid = 1; miss_line = 27'h20; miss_rd = 5'd10; issue(1, 1, 1, 2, 1);
      cyc("R6", 0);
      idle(); issue(0, 10, 1, 0, 0);           cyc("R6", 1);
      idle(); miss_valid = 1; miss_line = 27'h50; miss_rd = 5'd13; issue(1, 1, 1, 0, 0);
      cyc("R6 one entry used", 1);
      idle(); fill_valid = 1; fill_line = 27'h30; issue(0, 10, 1, 0, 0);
      cyc("R7 unknown line", 1);
      idle(); fill_valid = 1; fill_line = 27'h50; cyc("R7", -1);
      // release 0x20 and allocate 0x40 together
      idle(); fill_valid = 1; fill_line = 27'h20; miss_valid = 1; miss_line = 27'h40;
      miss_rd = 5'd11; issue(1, 0, 0, 0, 0);
      #1;
      chk("R7 merged wake", 64'(wake_mask), 64'(32'h400));
      cyc("R8", 0);
      // same line returns while a new miss to it arrives
      idle(); fill_valid = 1; fill_line = 27'h40; miss_valid = 1; miss_line = 27'h40;
      miss_rd = 5'd12; issue(0, 12, 1, 0, 0);
      cyc("R8 refill", 1);
      idle(); fill_valid = 1; fill_line = 27'h40; issue(0, 12, 1, 0, 0);
      #1;
      chk("R7 second fill", 64'(wake_mask), 64'(32'h1000));
      cyc("R7", 0);

      // constrained random
      idle();
      last_stall = 0;
      for (int n = 0; n < 4000; n++) begin
         bit prev_mem;
         bit es, ed, ef;
         logic [NREGS-1:0] ew;
         string tag;
         prev_mem = iss_valid && iss_mem && !last_stall;
         idle();
         if (prev_mem && ($urandom % 10) < 6) begin
            miss_valid = 1;
            miss_line  = 27'h100 + 27'($urandom % 4);
            miss_store = ($urandom % 10) < 3;
            miss_rd    = REG_W'($urandom % 8);
         end
         if (($urandom % 4) == 0) begin
            fill_valid = 1;
            fill_line  = 27'h100 + 27'($urandom % 5);
         end
         if (($urandom % 4) != 0)
            issue(($urandom % 2) == 1, $urandom % 8, ($urandom % 3) != 0,
                  $urandom % 8, ($urandom % 2) == 1);
         #0;
         model_eval(es, ed, ef, ew);
         tag = ed ? "R3" : ((iss_valid && iss_mem && ef) ? "R5" : "R2");
         cyc(tag, -1);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule